// File: doc/BRIEF.md
# Dual-Channel Mirrored Interrupt Register Unit

This unit is a small slice of configuration space for a two-channel disk controller. Each drive channel has one interrupt pending flag, and software can see that flag in two places. The first is a shared mode byte. The second is a legacy byte that belongs to the channel. Both locations always report the same value. Software clears a flag by writing a one to it at either location, and the other location follows.

Each channel drives an interrupt level input. A rising level sets the channel's flag and a falling level clears it. The shared mode byte also carries one blocking bit per channel. A separate side port sets or clears those blocking bits. The unit ORs the unblocked pending flags onto a single registered, level-sensitive interrupt line.

Configuration reads are registered. The read data appears one clock after the address is presented and reflects the state before that edge.

Top module: `irq_mirror_regs`

## Requirements
- R1: After synchronous reset, both pending flags and both blocking bits are 0, `irq_o` is 0, and the bytes at 0x50, 0x57 and 0x71 read 0x00.
- R2: A 0-to-1 change on `ch_lvl_i[n]` sets channel n's pending flag. In the mode byte at 0x71, bit 2 holds the channel 0 flag and bit 3 holds the channel 1 flag.
- R3: A 1-to-0 change on `ch_lvl_i[n]` clears channel n's pending flag.
- R4: The channel 0 flag also reads at bit 2 of offset 0x50. The channel 1 flag also reads at bit 4 of offset 0x57. These copies always equal the mode byte's bits.
- R5: A configuration write to 0x71 clears the channel 0 flag when data bit 2 is 1 and the channel 1 flag when data bit 3 is 1. Data bits that are 0 leave the flags unchanged.
- R6: A configuration write to 0x50 with data bit 2 set clears the channel 0 flag. A write to 0x57 with data bit 4 set clears the channel 1 flag. The mode byte follows in both cases.
- R7: Configuration writes change no bit of the three bytes other than clearing the pending flags. This includes the blocking bits at bits 4 and 5 of 0x71. Bits without a function read 0.
- R8: `irq_o` is high exactly when (channel 0 pending and bit 4 of 0x71 is clear) or (channel 1 pending and bit 5 of 0x71 is clear). It updates on the same edge as the state it depends on.
- R9: A side-port write loads bits 4 and 5 of `side_wdata_i` into the blocking bits, bit 4 blocking channel 0 and bit 5 blocking channel 1. The other data bits are ignored.
- R10: When a level change and a write-one-to-clear hit the same channel in the same cycle, the level change decides the flag.
- R11: Any other configuration offset reads 0x00, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_lvl_i | input | 2 | Interrupt level from each drive channel |
| cfg_wr_i | input | 1 | Configuration byte write strobe |
| cfg_addr_i | input | ADDR_W | Configuration byte offset for both read and write |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Registered configuration read data |
| side_wr_i | input | 1 | Side-port mode byte write strobe |
| side_wdata_i | input | 8 | Side-port write data; only bits 4 and 5 are used |
| irq_o | output | 1 | Registered combined interrupt level |

## Verification
The assertions assume that the channel level inputs are already synchronous to `clk`. They also assume that the strobes are clean single-cycle levels sampled at the rising edge. The bench changes every input on the falling edge, so each change is seen at exactly one rising edge. It holds the levels steady between scenarios. It drives a level change together with a clear write only in the one scenario that exercises the priority rule.

// File: rtl/irqm_pkg.sv
package irqm_pkg;
  localparam int NUM_CH = 2;
  localparam int BYTE_W = 8;

  localparam logic [7:0] OFS_LEG0 = 8'h50;
  localparam logic [7:0] OFS_LEG1 = 8'h57;
  localparam logic [7:0] OFS_MODE = 8'h71;

  localparam int MODE_PEND_LSB = 2;
  localparam int MODE_BLK_LSB  = 4;

  function automatic logic [7:0] leg_ofs(input int ch);
    return (ch == 0) ? OFS_LEG0 : OFS_LEG1;
  endfunction

  function automatic int leg_bit(input int ch);
    return (ch == 0) ? 2 : 4;
  endfunction
endpackage

// File: rtl/irqm_chan.sv
module irqm_chan (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  input  logic clr_i,
  output logic pend_o,
  output logic pend_nxt_o
);
  logic lvl_q;
  logic rise;
  logic fall;

  assign rise = lvl_i & ~lvl_q;
  assign fall = ~lvl_i & lvl_q;

  always_comb begin
    if (rise)       pend_nxt_o = 1'b1;
    else if (fall)  pend_nxt_o = 1'b0;
    else if (clr_i) pend_nxt_o = 1'b0;
    else            pend_nxt_o = pend_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q  <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      lvl_q  <= lvl_i;
      pend_o <= pend_nxt_o;
    end
  end

  p_rise_sets_r2: assert property (@(posedge clk) disable iff (rst)
    rise |=> pend_o);
  p_fall_clears_r3: assert property (@(posedge clk) disable iff (rst)
    fall |=> !pend_o);
  p_prio_r10: assert property (@(posedge clk) disable iff (rst)
    (rise && clr_i) |=> pend_o);
  p_w1c_r5: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !rise) |=> !pend_o);
endmodule

// File: rtl/irqm_combine.sv
module irqm_combine #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              side_wr_i,
  input  logic [NUM_CH-1:0] side_blk_i,
  input  logic [NUM_CH-1:0] pend_i,
  input  logic [NUM_CH-1:0] pend_nxt_i,
  output logic [NUM_CH-1:0] blk_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0] blk_nxt;

  assign blk_nxt = side_wr_i ? side_blk_i : blk_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_o <= '0;
      irq_o <= 1'b0;
    end else begin
      blk_o <= blk_nxt;
      irq_o <= |(pend_nxt_i & ~blk_nxt);
    end
  end

  p_irq_level_r8: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(pend_i & ~blk_o));
  p_side_load_r9: assert property (@(posedge clk) disable iff (rst)
    side_wr_i |=> blk_o == $past(side_blk_i));
  p_blk_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !side_wr_i |=> $stable(blk_o));
endmodule

// File: rtl/irqm_view.sv
module irqm_view
  import irqm_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NUM_CH-1:0] pend_i,
  input  logic [NUM_CH-1:0] blk_i,
  output logic [BYTE_W-1:0] rdata_o
);
  logic [BYTE_W-1:0] view;

  always_comb begin
    view = '0;
    if (addr_i == ADDR_W'(OFS_MODE)) begin
      for (int c = 0; c < NUM_CH; c++) begin
        view[MODE_PEND_LSB + c] = pend_i[c];
        view[MODE_BLK_LSB + c]  = blk_i[c];
      end
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (addr_i == ADDR_W'(leg_ofs(c))) view[leg_bit(c)] = pend_i[c];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= view;
  end

  p_reset_read_r1: assert property (@(posedge clk)
    $past(rst) |-> rdata_o == '0);
endmodule

// File: rtl/irq_mirror_regs.sv
module irq_mirror_regs
  import irqm_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        ch_lvl_i,
  input  logic              cfg_wr_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [7:0]        cfg_wdata_i,
  output logic [7:0]        cfg_rdata_o,
  input  logic              side_wr_i,
  input  logic [7:0]        side_wdata_i,
  output logic              irq_o
);
  logic              wr_mode;
  logic [NUM_CH-1:0] clr;
  logic [NUM_CH-1:0] pend;
  logic [NUM_CH-1:0] pend_nxt;
  logic [NUM_CH-1:0] blk;

  assign wr_mode = cfg_wr_i && (cfg_addr_i == ADDR_W'(OFS_MODE));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic wr_leg;
    assign wr_leg = cfg_wr_i && (cfg_addr_i == ADDR_W'(leg_ofs(c)));
    assign clr[c] = (wr_mode && cfg_wdata_i[MODE_PEND_LSB + c]) ||
                    (wr_leg  && cfg_wdata_i[leg_bit(c)]);

    irqm_chan u_chan (
      .clk        (clk),
      .rst        (rst),
      .lvl_i      (ch_lvl_i[c]),
      .clr_i      (clr[c]),
      .pend_o     (pend[c]),
      .pend_nxt_o (pend_nxt[c])
    );
  end

  irqm_combine #(.NUM_CH(NUM_CH)) u_comb (
    .clk        (clk),
    .rst        (rst),
    .side_wr_i  (side_wr_i),
    .side_blk_i (side_wdata_i[MODE_BLK_LSB +: NUM_CH]),
    .pend_i     (pend),
    .pend_nxt_i (pend_nxt),
    .blk_o      (blk),
    .irq_o      (irq_o)
  );

  irqm_view #(.ADDR_W(ADDR_W)) u_view (
    .clk     (clk),
    .rst     (rst),
    .addr_i  (cfg_addr_i),
    .pend_i  (pend),
    .blk_i   (blk),
    .rdata_o (cfg_rdata_o)
  );

  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!irq_o && pend == '0 && blk == '0));
endmodule

// File: tb/irq_mirror_regs_bench.sv
module irq_mirror_regs_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] ch_lvl = '0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       side_wr = 1'b0;
  logic [7:0] side_wdata = '0;
  logic       irq;
  int         n_chk = 0;
  int         n_bad = 0;

  always #2 clk = ~clk;

  irq_mirror_regs u_irq_mirror_regs (
    .clk          (clk),
    .rst          (rst),
    .ch_lvl_i     (ch_lvl),
    .cfg_wr_i     (cfg_wr),
    .cfg_addr_i   (cfg_addr),
    .cfg_wdata_i  (cfg_wdata),
    .cfg_rdata_o  (cfg_rdata),
    .side_wr_i    (side_wr),
    .side_wdata_i (side_wdata),
    .irq_o        (irq)
  );

  task automatic chk_rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); cfg_addr = a;
    @(posedge clk); #1;
    n_chk++;
    if (cfg_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s: offset %h read %h expected %h", tag, a, cfg_rdata, exp);
    end
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    @(negedge clk);
    n_chk++;
    if (irq !== exp) begin
      n_bad++;
      $display("FAIL %s: irq %b expected %b", tag, irq, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic side_write(input logic [7:0] d);
    @(negedge clk); side_wr = 1'b1; side_wdata = d;
    @(negedge clk); side_wr = 1'b0;
  endtask

  task automatic set_lvl(input int ch, input logic v);
    @(negedge clk); ch_lvl[ch] = v;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk_rd(8'h71, 8'h00, "R1 mode");
    chk_rd(8'h50, 8'h00, "R1 leg0");
    chk_rd(8'h57, 8'h00, "R1 leg1");
    chk_irq(1'b0, "R1 irq");
  endtask

  task automatic t_set;
    set_lvl(0, 1'b1);
    chk_rd(8'h71, 8'h04, "R2 ch0 set");
    chk_rd(8'h50, 8'h04, "R4 leg0 copy");
    chk_rd(8'h57, 8'h00, "R4 leg1 idle");
    chk_irq(1'b1, "R8 ch0 unblocked");
    set_lvl(1, 1'b1);
    chk_rd(8'h71, 8'h0C, "R2 ch1 set");
    chk_rd(8'h57, 8'h10, "R4 leg1 copy");
  endtask

  task automatic t_w1c_mode;
    cfg_write(8'h71, 8'h00);
    chk_rd(8'h71, 8'h0C, "R5 zero write no effect");
    cfg_write(8'h71, 8'h04);
    chk_rd(8'h71, 8'h08, "R5 clear ch0");
    chk_rd(8'h50, 8'h00, "R4 leg0 follows");
  endtask

  task automatic t_w1c_leg;
    cfg_write(8'h57, 8'h10);
    chk_rd(8'h71, 8'h00, "R6 clear ch1 via leg");
    chk_irq(1'b0, "R8 none pending");
    set_lvl(0, 1'b0);
    set_lvl(0, 1'b1);
    chk_rd(8'h71, 8'h04, "R2 ch0 re-set");
    cfg_write(8'h50, 8'h04);
    chk_rd(8'h71, 8'h00, "R6 clear ch0 via leg");
  endtask

  task automatic t_ignore;
    cfg_write(8'h50, 8'hFB);
    cfg_write(8'h57, 8'hEF);
    cfg_write(8'h71, 8'hF3);
    chk_rd(8'h50, 8'h00, "R7 leg0 other bits");
    chk_rd(8'h57, 8'h00, "R7 leg1 other bits");
    chk_rd(8'h71, 8'h00, "R7 mode blk not writable");
  endtask

  task automatic t_block;
    set_lvl(0, 1'b0);
    set_lvl(1, 1'b0);
    set_lvl(0, 1'b1);
    chk_irq(1'b1, "R8 ch0 pending");
    side_write(8'hDF);
    chk_rd(8'h71, 8'h14, "R9 blk0 loaded");
    chk_irq(1'b0, "R8 ch0 blocked");
    side_write(8'h20);
    chk_rd(8'h71, 8'h24, "R9 blk1 only");
    chk_irq(1'b1, "R8 ch0 unblocked");
    set_lvl(1, 1'b1);
    chk_rd(8'h71, 8'h2C, "R2 ch1 while blocked");
    side_write(8'h30);
    chk_irq(1'b0, "R8 both blocked");
    side_write(8'h00);
    chk_irq(1'b1, "R8 both unblocked");
  endtask

  task automatic t_fall;
    set_lvl(0, 1'b0);
    chk_rd(8'h71, 8'h08, "R3 ch0 fall");
    set_lvl(1, 1'b0);
    chk_rd(8'h71, 8'h00, "R3 ch1 fall");
    chk_irq(1'b0, "R8 idle");
  endtask

  task automatic t_prio;
    @(negedge clk);
    ch_lvl[0] = 1'b1; cfg_wr = 1'b1; cfg_addr = 8'h71; cfg_wdata = 8'h04;
    @(negedge clk); cfg_wr = 1'b0;
    chk_rd(8'h71, 8'h04, "R10 rise beats clear");
    cfg_write(8'h50, 8'h04);
    chk_rd(8'h71, 8'h00, "R6 clear with steady level");
  endtask

  task automatic t_other;
    cfg_write(8'h52, 8'hFF);
    chk_rd(8'h52, 8'h00, "R11 unmapped offset");
    chk_rd(8'h00, 8'h00, "R11 offset zero");
    chk_rd(8'h71, 8'h00, "R11 no side effect");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_set();
    t_w1c_mode();
    t_w1c_leg();
    t_ignore();
    t_block();
    t_fall();
    t_prio();
    t_other();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule